// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 128K bytes. The requester offers one access at a time over a valid/ready handshake that carries a write flag, a 17-bit address and a write byte. The controller then drives the memory's three active-low strobes (chip enable, write enable, output enable), its address lines and its bidirectional data bus through separate out, in and drive-enable signals.

Each phase of an access lasts a whole number of system clock cycles, set by parameters. Read access, write-strobe width, write-data setup and bus turnaround each come from rounding up the memory's nanosecond limit for the chosen clock period. Read data is sampled on the final cycle of the access window and is handed back with a one-cycle valid pulse. The sequencing keeps the memory's output drivers and the controller's drivers from ever meeting on the bus.

The defaults suit a 4 ns clock: a 3-cycle read, a 2-cycle write strobe, 2 cycles of data setup and 2 cycles of turnaround.

Top module: `sram_ctl`

## Requirements
- R1: After reset, chip enable, write enable and output enable are all high (inactive), the data drive enable is low, ready is high and read-valid is low.
- R2: A request accepted with the write flag at 1 stores its byte at its address. The write occurs only while chip enable and write enable are both low, and a later read of that address returns the byte.
- R3: A request accepted with the write flag at 0 holds chip enable and output enable low with write enable high for RD_CYC cycles. It samples the data input on the last of those cycles and returns it on the read-data output with a read-valid pulse exactly one cycle wide.
- R4: Write enable stays low for at least max(WE_CYC, SU_CYC) consecutive cycles. The write byte is driven and unchanged for at least SU_CYC cycles before write enable rises, and is still driven in the cycle in which write enable is seen high again.
- R5: While chip enable is low, the memory address does not change.
- R6: The data drive enable is high only while output enable is high, and only after output enable has been high for at least TA_CYC complete cycles.
- R7: The data drive enable is low in the cycle before output enable falls.
- R8: Ready is low from the cycle after a request is accepted until the access finishes, so at most one access is in flight.
- R9: Write enable and output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester offers an access |
| req_ready | output | 1 | Controller can take an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: read data is valid |
| rd_data | output | DW | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory address lines |
| mem_dq_out | output | DW | Data the controller drives onto the bus |
| mem_dq_in | input | DW | Data seen on the bus |
| mem_dq_oe | output | 1 | Controller drives the bus when high |

## Verification
The bench's memory model returns a poison byte until output enable has been low long enough. A controller that samples too early therefore reads the wrong value. Requests run back to back, so a read is directly followed by a write and a write by a read. A controller with a short or missing turnaround drives the bus while the memory is still driving it or has not yet let go, and the model flags it. The model also measures the write strobe and the data setup on every write, so a strobe that is too narrow, or data that shows up late or drops before the rising edge, is reported. An address that moves during an access is caught, and so is a write to the first and last addresses or an overwrite that lands in the wrong word.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int RD_CYC = 3,
  parameter int WE_CYC = 2,
  parameter int SU_CYC = 2,
  parameter int TA_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int PW   = (WE_CYC > SU_CYC) ? WE_CYC : SU_CYC;
  localparam int MX0  = (RD_CYC > PW) ? RD_CYC : PW;
  localparam int MAXC = (MX0 > TA_CYC) ? MX0 : TA_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WA, S_WP, S_WH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] oe_hi;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;
  logic          rv_q;

  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = (st == S_IDLE);
  assign mem_oe_n   = (st != S_RD);
  assign mem_we_n   = (st != S_WP);
  assign mem_dq_oe  = (st == S_WP) || (st == S_WH);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wd_q;
  assign rd_valid   = rv_q;
  assign rd_data    = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      oe_hi  <= CW'(TA_CYC);
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (st == S_RD)                oe_hi <= '0;
      else if (oe_hi != CW'(TA_CYC)) oe_hi <= oe_hi + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          cnt    <= '0;
          st     <= req_write ? S_WA : S_RD;
        end
        S_RD: if (cnt == CW'(RD_CYC - 1)) begin
          rd_q <= mem_dq_in;
          rv_q <= 1'b1;
          st   <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_WA: if (int'(oe_hi) + 1 >= TA_CYC) begin
          cnt <= '0;
          st  <= S_WP;
        end
        S_WP: if (cnt == CW'(PW - 1)) st <= S_WH;
              else cnt <= cnt + 1'b1;
        S_WH: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] we_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                  we_run <= '0;
    else if (mem_we_n)           we_run <= '0;
    else if (we_run != CW'(MAXC)) we_run <= we_run + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst_n) |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready));
  assert_we_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  assert_rdv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_run) >= PW && mem_dq_oe));
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  assert_no_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !req_ready);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;
  localparam int TWE = 2, TSU = 2, TTA = 2, TOE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dq_out;
  logic [7:0] mem_dq_in = 8'hEE;
  logic [16:0] mem_addr;

  always #2 clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: stores bytes, drives reads, measures protocol timing
  logic [7:0] mem [logic [16:0]];
  logic [16:0] p_addr;
  logic [7:0]  p_dout;
  logic p_we, p_oe, p_ce, p_doe;
  int oe_hi, oe_lo, we_lo, drv;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_we = 1; p_oe = 1; p_ce = 1; p_doe = 0; p_addr = '0; p_dout = '0;
      oe_hi = 99; oe_lo = 0; we_lo = 0; drv = 0;
      mem_dq_in = 8'hEE;
    end else begin
      if (mem_dq_oe && (!mem_oe_n || oe_hi < TTA)) chk(0, "R6 bus clash", oe_hi, TTA);
      if (!mem_we_n && !mem_oe_n) chk(0, "R9 we and oe low", 0, 1);
      if (p_oe && !mem_oe_n && p_doe) chk(0, "R7 bus not released", 1, 0);
      if (!mem_ce_n && !p_ce && mem_addr != p_addr) chk(0, "R5 address moved", mem_addr, p_addr);
      if (!mem_we_n && mem_ce_n) chk(0, "R2 write without ce", 1, 0);
      if (!mem_we_n) begin
        we_lo++;
        if (!mem_dq_oe) drv = 0;
        else if (drv == 0 || mem_dq_out == p_dout) drv++;
        else drv = 1;
      end
      if (!p_we && mem_we_n) begin
        if (we_lo < TWE) chk(0, "R4 we pulse", we_lo, TWE);
        if (drv < TSU) chk(0, "R4 data setup", drv, TSU);
        if (!(mem_dq_oe && mem_dq_out == p_dout)) chk(0, "R4 data hold", mem_dq_out, p_dout);
        mem[p_addr] = p_dout;
        we_lo = 0; drv = 0;
      end
      if (mem_oe_n) begin oe_hi++; oe_lo = 0; end
      else begin oe_lo++; oe_hi = 0; end
      if (!mem_ce_n && !mem_oe_n && mem_we_n && oe_lo >= TOE)
        mem_dq_in = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
      else
        mem_dq_in = 8'hEE;
      p_we = mem_we_n; p_oe = mem_oe_n; p_ce = mem_ce_n; p_doe = mem_dq_oe;
      p_addr = mem_addr; p_dout = mem_dq_out;
    end
  end

  // {write, addr, wdata, expected read}
  localparam logic [33:0] VEC [12] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
    {1'b1, 17'h0AAAA, 8'h3C, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
    {1'b1, 17'h0AAAA, 8'hC3, 8'h00},
    {1'b0, 17'h0AAAA, 8'h00, 8'hC3},
    {1'b1, 17'h15555, 8'h00, 8'h00},
    {1'b0, 17'h15555, 8'h00, 8'h00},
    {1'b1, 17'h00001, 8'hFF, 8'h00},
    {1'b0, 17'h00001, 8'h00, 8'hFF},
    {1'b0, 17'h00000, 8'h00, 8'hA5}
  };

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic get_read(input logic [7:0] exp, input string tag);
    int w = 0;
    while (!rd_valid && w < 50) begin @(negedge clk); w++; end
    chk(rd_valid, {tag, " R3 rd_valid"}, rd_valid, 1);
    chk(rd_data == exp, {tag, " R2/R3 data"}, rd_data, exp);
    @(negedge clk);
    chk(!rd_valid, "R3 rd_valid width", rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe, "R1 drive", mem_dq_oe, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][33], VEC[i][32:16], VEC[i][15:8]);
      if (!VEC[i][33]) get_read(VEC[i][7:0], "table");
    end

    // R8: ready low while an access runs, a held request is not re-taken
    req_valid = 1; req_write = 1; req_addr = 17'h00123; req_wdata = 8'h77;
    @(negedge clk);
    chk(!req_ready, "R8 ready during write", req_ready, 0);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    issue(0, 17'h00123, 8'h00);
    chk(!req_ready, "R8 ready during read", req_ready, 0);
    get_read(8'h77, "R8 follow-up");

    // write right after a read at the top address, then read back
    issue(0, 17'h1FFFF, 8'h00);
    get_read(8'h5A, "R6 pre");
    issue(1, 17'h1FFFF, 8'h81);
    issue(0, 17'h1FFFF, 8'h00);
    get_read(8'h81, "R6 turnaround");

    repeat (5) @(negedge clk);
    chk(mem_ce_n && !mem_dq_oe, "R7 idle released", {mem_ce_n, mem_dq_oe}, 2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule